// File: doc/BRIEF.md
# Read-Sequence Command Detector

This block monitors the access stream of a small static memory and spots two special patterns of six consecutive reads. Both patterns use the same five leading addresses. The sixth address decides which command is raised. One command asks a transfer engine to copy the memory contents into nonvolatile cells (a store). The other asks it to copy them back (a recall). The detector only observes. It never blocks or alters an access, so every read in a pattern is still served as an ordinary read.

An access is one clock cycle with the access strobe high. The read/write qualifier and the 13-bit address are sampled in that cycle. Cycles with the strobe low are not accesses and leave the progress unchanged. Any write, or any read that is not the expected next address, cancels a partial pattern. While the transfer engine reports busy, all accesses are ignored and the detector stays idle.

Top module: `cmdseq_detector`

## Requirements
- R1: Reads of 0x0000, 0x1555, 0x0AAA, 0x1FFF, 0x10F0 and then 0x0F0F, accepted in that order, raise `store_req` for exactly the one cycle after the clock edge that accepts the sixth read. `recall_req` stays low.
- R2: The same five leading reads followed by a read of 0x0F0E raise `recall_req` for exactly the one cycle after the edge that accepts that read. `store_req` stays low.
- R3: A write (`acc_is_read` = 0) at any point in a pattern cancels it, even if the write uses the expected address. Completing the remaining steps afterwards raises no request.
- R4: A read of any address other than the next expected one cancels the pattern, and the remaining steps then raise no request.
- R5: If the cancelling access is a read of 0x0000, it counts as the first step of a new pattern.
- R6: Cycles with `acc_valid` low between steps neither advance nor cancel a pattern.
- R7: While `busy` is high, accesses are ignored, the pattern is cleared to idle, and no request is raised.
- R8: `store_req` and `recall_req` are never high in the same cycle, and each is high for one cycle per completed pattern.
- R9: A synchronous reset (`rst_n` low at a clock edge) drives both requests low and discards any partial pattern.
- R10: A sixth read that matches neither final address raises no request. A later lone read of a final address also raises none, so a new pattern must start again from 0x0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_valid | input | 1 | High in each cycle that carries a memory access |
| acc_is_read | input | 1 | 1 = read access, 0 = write access |
| acc_addr | input | 13 | Address of the access |
| busy | input | 1 | Transfer engine busy; accesses are ignored |
| store_req | output | 1 | One-cycle store command pulse |
| recall_req | output | 1 | One-cycle recall command pulse |

## Verification
The store and recall decisions share their whole prefix and are taken at the same step, so both can be candidates in one cycle. The bench completes the prefix and then presents each final address, including two patterns run back to back. It also presents a near-miss final address that differs in the low bits. In every case it requires exactly the expected one of the two pulses and never both. A second coincidence is `busy` rising in the same cycle as a sixth read that would otherwise complete a pattern. There the bench requires that no pulse appears and that the following pattern is detected normally.

// File: rtl/cmdseq_pkg.sv
package cmdseq_pkg;

    localparam int CMD_ADDR_W = 13;
    localparam int PREFIX_LEN = 5;
    localparam int STEP_W     = $clog2(PREFIX_LEN + 1);

    typedef logic [CMD_ADDR_W-1:0] cmd_addr_t;

    // shared leading addresses, in the order they must be read
    localparam cmd_addr_t PREFIX_ADDR [PREFIX_LEN] = '{
        13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0
    };

    localparam cmd_addr_t STORE_LAST  = 13'h0F0F;
    localparam cmd_addr_t RECALL_LAST = 13'h0F0E;

    typedef struct packed {
        logic [STEP_W-1:0] step;    // number of prefix steps matched
        logic              store;
        logic              recall;
    } det_state_t;

endpackage

// File: rtl/cmdseq_step_match.sv
module cmdseq_step_match
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = CMD_ADDR_W
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [STEP_W-1:0] step,
    output logic              prefix_hit,
    output logic              first_hit,
    output logic              store_hit,
    output logic              recall_hit
);

    logic [PREFIX_LEN-1:0] addr_eq;
    logic [PREFIX_LEN-1:0] step_sel;

    for (genvar i = 0; i < PREFIX_LEN; i++) begin : g_prefix
        assign addr_eq[i]  = (addr == ADDR_W'(PREFIX_ADDR[i]));
        assign step_sel[i] = (step == STEP_W'(i));
    end

    logic at_final;
    assign at_final   = (step == STEP_W'(PREFIX_LEN));
    assign prefix_hit = |(addr_eq & step_sel);
    assign first_hit  = addr_eq[0];
    assign store_hit  = at_final && (addr == ADDR_W'(STORE_LAST));
    assign recall_hit = at_final && (addr == ADDR_W'(RECALL_LAST));

endmodule

// File: rtl/cmdseq_detector.sv
module cmdseq_detector
    import cmdseq_pkg::*;
#(
    parameter int ADDR_W = CMD_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic              acc_is_read,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              busy,
    output logic              store_req,
    output logic              recall_req
);

    det_state_t st_d, st_q;

    logic prefix_hit, first_hit, store_hit, recall_hit;

    cmdseq_step_match #(.ADDR_W(ADDR_W)) u_match (
        .addr       (acc_addr),
        .step       (st_q.step),
        .prefix_hit (prefix_hit),
        .first_hit  (first_hit),
        .store_hit  (store_hit),
        .recall_hit (recall_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.store  = 1'b0;
        st_d.recall = 1'b0;
        if (busy) begin
            st_d.step = '0;
        end else if (acc_valid) begin
            if (acc_is_read && prefix_hit) begin
                st_d.step = st_q.step + 1'b1;
            end else if (acc_is_read && store_hit) begin
                st_d.step  = '0;
                st_d.store = 1'b1;
            end else if (acc_is_read && recall_hit) begin
                st_d.step   = '0;
                st_d.recall = 1'b1;
            end else begin
                // abort; a read of the first address restarts the pattern
                st_d.step = (acc_is_read && first_hit) ? STEP_W'(1) : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign store_req  = st_q.store;
    assign recall_req = st_q.recall;

endmodule

// File: rtl/cmdseq_checker.sv
module cmdseq_checker #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic              acc_is_read,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              busy,
    input logic              store_req,
    input logic              recall_req
);

    AST_STORE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |-> $past(acc_valid && acc_is_read && !busy && acc_addr == ADDR_W'(13'h0F0F))); // R1
    AST_RECALL_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |-> $past(acc_valid && acc_is_read && !busy && acc_addr == ADDR_W'(13'h0F0E))); // R2
    AST_WRITE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_is_read) |=> !(store_req || recall_req)); // R3
    AST_BUSY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !(store_req || recall_req)); // R7
    AST_NO_DUAL_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !(store_req && recall_req)); // R8
    AST_STORE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        store_req |=> !store_req); // R8
    AST_RECALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        recall_req |=> !recall_req); // R8
    AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> !(store_req || recall_req)); // R6

endmodule

bind cmdseq_detector cmdseq_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .acc_valid   (acc_valid),
    .acc_is_read (acc_is_read),
    .acc_addr    (acc_addr),
    .busy        (busy),
    .store_req   (store_req),
    .recall_req  (recall_req)
);

// File: tb/tb_cmdseq_detector.sv
`timescale 1ns/1ps
module tb_cmdseq_detector;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_valid = 1'b0;
    logic        acc_is_read = 1'b0;
    logic [12:0] acc_addr = '0;
    logic        busy = 1'b0;
    logic        store_req, recall_req;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    logic got_st, got_rc;

    localparam logic [12:0] PFX [5] = '{13'h0000, 13'h1555, 13'h0AAA, 13'h1FFF, 13'h10F0};
    localparam logic [12:0] A_STORE  = 13'h0F0F;
    localparam logic [12:0] A_RECALL = 13'h0F0E;

    always #4 clk = ~clk;

    cmdseq_detector dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .acc_valid   (acc_valid),
        .acc_is_read (acc_is_read),
        .acc_addr    (acc_addr),
        .busy        (busy),
        .store_req   (store_req),
        .recall_req  (recall_req)
    );

    task automatic chk(input string tag, input logic exp_st, input logic exp_rc);
        n_tests++;
        if (got_st !== exp_st || got_rc !== exp_rc) begin
            n_fail++;
            $display("FAIL %s: store/recall actual=%b%b expected=%b%b",
                     tag, got_st, got_rc, exp_st, exp_rc);
        end
    endtask

    // present one access at a negedge; outputs are captured at the next negedge
    task automatic acc(input logic rd, input logic [12:0] a);
        acc_valid   = 1'b1;
        acc_is_read = rd;
        acc_addr    = a;
        @(negedge clk);
        got_st    = store_req;
        got_rc    = recall_req;
        acc_valid = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
        got_st = store_req;
        got_rc = recall_req;
    endtask

    task automatic send_prefix(input string tag);
        for (int i = 0; i < 5; i++) begin
            acc(1'b1, PFX[i]);
            chk(tag, 1'b0, 1'b0);
        end
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) idle();
        chk("R9 reset state", 1'b0, 1'b0);
        rst_n = 1'b1;
        send_prefix("R9 prefix");
        rst_n = 1'b0;
        idle();
        rst_n = 1'b1;
        acc(1'b1, A_STORE);
        chk("R9 partial discarded", 1'b0, 1'b0);
    endtask

    task automatic t_store();
        send_prefix("R1 prefix");
        acc(1'b1, A_STORE);
        chk("R1 store pulse", 1'b1, 1'b0);
        idle();
        chk("R8 store one cycle", 1'b0, 1'b0);
    endtask

    task automatic t_recall();
        send_prefix("R2 prefix");
        acc(1'b1, A_RECALL);
        chk("R2 recall pulse", 1'b0, 1'b1);
        idle();
        chk("R8 recall one cycle", 1'b0, 1'b0);
    endtask

    task automatic t_gaps();
        for (int i = 0; i < 5; i++) begin
            acc(1'b1, PFX[i]);
            repeat (i + 1) idle();
        end
        acc(1'b1, A_STORE);
        chk("R6 gaps tolerated", 1'b1, 1'b0);
    endtask

    task automatic t_write_abort();
        acc(1'b1, PFX[0]); acc(1'b1, PFX[1]); acc(1'b1, PFX[2]);
        acc(1'b0, PFX[3]);
        acc(1'b1, PFX[4]); acc(1'b1, A_STORE);
        chk("R3 write mid pattern", 1'b0, 1'b0);
        send_prefix("R3 prefix");
        acc(1'b0, A_RECALL);
        chk("R3 write at final step", 1'b0, 1'b0);
        acc(1'b1, A_RECALL);
        chk("R3 read after final write", 1'b0, 1'b0);
    endtask

    task automatic t_stray_read();
        acc(1'b1, PFX[0]); acc(1'b1, PFX[1]);
        acc(1'b1, 13'h0123);
        acc(1'b1, PFX[2]); acc(1'b1, PFX[3]); acc(1'b1, PFX[4]);
        acc(1'b1, A_STORE);
        chk("R4 stray read", 1'b0, 1'b0);
        acc(1'b1, PFX[0]); acc(1'b1, PFX[1]); acc(1'b1, PFX[1]);
        acc(1'b1, PFX[2]); acc(1'b1, PFX[3]); acc(1'b1, PFX[4]);
        acc(1'b1, A_RECALL);
        chk("R4 repeated step", 1'b0, 1'b0);
    endtask

    task automatic t_restart();
        acc(1'b1, PFX[0]); acc(1'b1, PFX[1]); acc(1'b1, PFX[2]);
        send_prefix("R5 restart prefix");
        acc(1'b1, A_RECALL);
        chk("R5 abort read counts as step one", 1'b0, 1'b1);
        send_prefix("R5 prefix");
        acc(1'b1, PFX[0]);
        chk("R5 first addr at final step", 1'b0, 1'b0);
        for (int i = 1; i < 5; i++) acc(1'b1, PFX[i]);
        acc(1'b1, A_STORE);
        chk("R5 restarted from final step", 1'b1, 1'b0);
    endtask

    task automatic t_bad_final();
        send_prefix("R10 prefix");
        acc(1'b1, 13'h0F0D);
        chk("R10 wrong final", 1'b0, 1'b0);
        acc(1'b1, A_STORE);
        chk("R10 lone final", 1'b0, 1'b0);
        acc(1'b1, A_RECALL);
        chk("R10 lone recall final", 1'b0, 1'b0);
    endtask

    task automatic t_busy();
        acc(1'b1, PFX[0]); acc(1'b1, PFX[1]); acc(1'b1, PFX[2]);
        busy = 1'b1;
        acc(1'b1, PFX[3]);
        chk("R7 busy access", 1'b0, 1'b0);
        busy = 1'b0;
        acc(1'b1, PFX[4]); acc(1'b1, A_STORE);
        chk("R7 busy ignored access", 1'b0, 1'b0);
        send_prefix("R7 prefix");
        busy = 1'b1;
        acc(1'b1, A_STORE);
        chk("R7 busy at final", 1'b0, 1'b0);
        busy = 1'b0;
        acc(1'b1, A_STORE);
        chk("R7 cleared by busy", 1'b0, 1'b0);
        send_prefix("R7 after busy");
        acc(1'b1, A_RECALL);
        chk("R7 normal after busy", 1'b0, 1'b1);
    endtask

    task automatic t_back_to_back();
        send_prefix("R8 b2b prefix");
        acc(1'b1, A_STORE);
        chk("R8 b2b store", 1'b1, 1'b0);
        acc(1'b1, PFX[0]);
        chk("R8 b2b gap", 1'b0, 1'b0);
        for (int i = 1; i < 5; i++) acc(1'b1, PFX[i]);
        acc(1'b1, A_RECALL);
        chk("R8 b2b recall", 1'b0, 1'b1);
    endtask

    initial begin
        #(8ns * 100000);
        if (!done) begin
            n_fail++;
            n_tests++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_store();
        t_recall();
        t_gaps();
        t_write_abort();
        t_stray_read();
        t_restart();
        t_bad_final();
        t_busy();
        t_back_to_back();
        repeat (2) idle();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule